// File: doc/BRIEF.md
# Camera Control Bus Register Master

This block drives the two-wire control bus of a camera sensor as the bus master. A host on the chip side gives it one command at a time: write one sensor register, read one sensor register, reset the sensor, or walk an initialisation list held in a small constant table. The block frames the bus traffic itself, with start and stop conditions, byte shifting and acknowledge slots. It holds `busy` high until the whole command has finished.

The bus pins are open-drain. The block only ever asks for a line to be pulled low (`scl_low`, `sda_low`) and reads the resolved data line back on `sda_in`. A register read takes two separate bus transactions. The first writes the register address and closes with a stop. The second opens with a fresh start, sends the read form of the device address, and clocks one byte in, which the master ends with a not-acknowledge. After the device-address byte and after the register-address byte the clock is parked low for a fixed guard gap. A sensor reset is an ordinary register write followed by a long wait. The initialisation list stops at a pair whose register and value are both all ones, and that pair is never sent.

The bus timing is derived from the system clock. `QTR` cycles make one quarter of a bus bit, `GAP_CYC` cycles make one guard gap, and `RESET_WAIT` cycles make the post-reset wait. The defaults assume a 100 MHz clock, a 50 kHz bus, a 20 µs gap and a 200 ms wait.

Top module: `cam_ctl_master`

## Requirements
- R1: Out of reset, `busy`, `scl_low`, `sda_low`, `ack_fail` are 0 and `rd_data` is 0x00.
- R2: `cmd_start` is taken only while `busy` is 0, and `busy` is 1 from the following cycle. `cmd_start` while busy has no effect on the bus or on the result. `cmd_op`: 0 = write, 1 = read, 2 = sensor reset, 3 = run initialisation list.
- R3: A write is: start, byte 0x42, byte `cmd_reg`, byte `cmd_wdata`, stop. Each byte is sent MSB first and is followed by a ninth acknowledge slot, during which the master releases SDA. One bit lasts 4×`QTR` cycles: SCL low `QTR`, high 2×`QTR`, low `QTR`, with SDA held for the whole bit. Start is SCL/SDA high `QTR`, SDA low with SCL high `QTR`, then both low 2×`QTR`. Stop is both low `QTR`, SCL high `QTR`, then both high 2×`QTR`.
- R4: A read is start, 0x42, `cmd_reg`, stop, followed at once by start, 0x43, eight received bits, one not-acknowledge slot (SDA released), stop.
- R5: After the acknowledge slot of each device-address byte (0x42 or 0x43) and of each register-address byte, SCL stays low with SDA released for `GAP_CYC` cycles. No other gap occurs.
- R6: While SCL is high, SDA changes only inside a command (the start fall and the stop rise). Bus lines are released whenever `busy` is 0.
- R7: The data line is sampled at the end of the second quarter of each bit. A high sample in the acknowledge slot of a transmitted byte does not alter the transfer but sets `ack_fail`, which is cleared when a command is taken and is valid once `busy` is 0.
- R8: The received byte is assembled MSB first and appears on `rd_data` when `busy` falls. It holds while `busy` is 0, and write, reset and list commands leave it unchanged.
- R9: A sensor reset writes 0x80 to register 0x12 as in R3, then keeps `busy` high with the lines released for `RESET_WAIT` cycles.
- R10: A list run spends one released-bus cycle fetching each entry and sends each non-terminal pair as a write per R3. It stops at the first pair 0xFF/0xFF (not sent), or after `ROM_DEPTH` entries. A pair with only one byte equal to 0xFF is sent. The default list is 11/80, 3B/1A, FF/00, 0C/04, FF/FF.
- R11: `busy` falls the cycle after the final stop ends (after the last fetch for a list, after the wait for a reset), and the last SCL/SDA state before that is both released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Command request, taken while idle |
| cmd_op | input | 2 | Command kind (0 write, 1 read, 2 sensor reset, 3 list) |
| cmd_reg | input | 8 | Sensor register address |
| cmd_wdata | input | 8 | Value for a register write |
| busy | output | 1 | Command in progress |
| rd_data | output | 8 | Byte from the last read |
| ack_fail | output | 1 | An acknowledge slot of the last command read high |
| scl_low | output | 1 | Pull the clock line low |
| sda_low | output | 1 | Pull the data line low |
| sda_in | input | 1 | Resolved level of the data line |

## Verification
The first bus cycle of a write, read or reset falls in the cycle right after the accepting edge, and a list run begins one fetch cycle later. Every later phase lands at a fixed offset that follows from `QTR`, `GAP_CYC` and `RESET_WAIT`. The bench expands each command into a queue of expected per-cycle SCL, SDA and slave-drive values. It compares the design against the queue at every falling edge and applies the slave's drive in that same cycle, so that the sample at the closing rising edge sees it. `rd_data` and `ack_fail` are due in the first cycle with `busy` low, and they are checked at that falling edge.

// File: rtl/cam_ctl_pkg.sv
package cam_ctl_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_RESET = 2'd2,
        OP_INIT  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SYM_START,
        SYM_STOP,
        SYM_BIT,
        SYM_GAP
    } sym_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_START,
        ST_BIT,
        ST_GAP,
        ST_STOP,
        ST_DELAY
    } stage_e;

    localparam logic [7:0] DEV_WR_ADDR  = 8'h42;
    localparam logic [7:0] DEV_RD_ADDR  = 8'h43;
    localparam logic [7:0] SOFT_RST_REG = 8'h12;
    localparam logic [7:0] SOFT_RST_VAL = 8'h80;
    localparam logic [7:0] LIST_END     = 8'hFF;

endpackage

// File: rtl/cam_sym_gen.sv
module cam_sym_gen
    import cam_ctl_pkg::*;
#(
    parameter int QTR     = 500,
    parameter int GAP_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  sym_e kind_i,
    input  logic bit_i,
    input  logic sda_in,
    output logic done,
    output logic scl_low,
    output logic sda_low,
    output logic smp
);

    localparam int MAXL = (QTR > GAP_CYC) ? QTR : GAP_CYC;
    localparam int CW   = $clog2(MAXL + 1);
    localparam logic [CW-1:0] Q_LAST = CW'(QTR - 1);
    localparam logic [CW-1:0] G_LAST = CW'(GAP_CYC - 1);

    typedef struct packed {
        logic          active;
        sym_e          kind;
        logic          bitv;
        logic [1:0]    qph;
        logic [CW-1:0] cnt;
        logic          smp;
    } gen_t;

    gen_t g_q, g_d;
    logic qend, lastq, scl_rel, sda_rel;

    always_comb begin
        qend  = (g_q.kind == SYM_GAP) ? (g_q.cnt == G_LAST) : (g_q.cnt == Q_LAST);
        lastq = (g_q.kind == SYM_GAP) ? 1'b1 : (g_q.qph == 2'd3);
        done  = g_q.active && qend && lastq;
        g_d   = g_q;
        if (g_q.active) begin
            if (qend) begin
                g_d.cnt = '0;
                g_d.qph = g_q.qph + 2'd1;
                if (g_q.kind == SYM_BIT && g_q.qph == 2'd1) begin
                    g_d.smp = sda_in;
                end
            end else begin
                g_d.cnt = g_q.cnt + CW'(1);
            end
            if (done) begin
                g_d.active = 1'b0;
            end
        end
        if (go) begin
            g_d.active = 1'b1;
            g_d.kind   = kind_i;
            g_d.bitv   = bit_i;
            g_d.qph    = 2'd0;
            g_d.cnt    = '0;
        end
    end

    always_comb begin
        scl_rel = 1'b1;
        sda_rel = 1'b1;
        if (g_q.active) begin
            case (g_q.kind)
                SYM_START: begin
                    scl_rel = (g_q.qph < 2'd2);
                    sda_rel = (g_q.qph == 2'd0);
                end
                SYM_STOP: begin
                    scl_rel = (g_q.qph != 2'd0);
                    sda_rel = (g_q.qph >= 2'd2);
                end
                SYM_BIT: begin
                    scl_rel = (g_q.qph == 2'd1) || (g_q.qph == 2'd2);
                    sda_rel = g_q.bitv;
                end
                default: begin
                    scl_rel = 1'b0;
                    sda_rel = 1'b1;
                end
            endcase
        end
    end

    assign scl_low = ~scl_rel;
    assign sda_low = ~sda_rel;
    assign smp     = g_q.smp;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

endmodule

// File: rtl/cam_init_rom.sv
module cam_init_rom #(
    parameter int DEPTH = 8,
    parameter int AW    = 3,
    parameter logic [DEPTH*16-1:0] LIST = '0
) (
    input  logic [AW-1:0] idx,
    output logic [7:0]    reg_o,
    output logic [7:0]    val_o
);

    logic [DEPTH-1:0][15:0] table_w;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign table_w[i] = LIST[i*16 +: 16];
    end

    always_comb begin
        reg_o = 8'hFF;
        val_o = 8'hFF;
        if (32'(idx) < DEPTH) begin
            reg_o = table_w[idx][15:8];
            val_o = table_w[idx][7:0];
        end
    end

endmodule

// File: rtl/cam_ctl_master.sv
module cam_ctl_master
    import cam_ctl_pkg::*;
#(
    parameter int QTR        = 500,
    parameter int GAP_CYC    = 2000,
    parameter int RESET_WAIT = 20_000_000,
    parameter int ROM_DEPTH  = 8,
    parameter logic [ROM_DEPTH*16-1:0] ROM_LIST = {
        16'h0000, 16'h0000, 16'h0000, 16'hFFFF,
        16'h0C04, 16'hFF00, 16'h3B1A, 16'h1180
    }
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_start,
    input  logic [1:0] cmd_op,
    input  logic [7:0] cmd_reg,
    input  logic [7:0] cmd_wdata,
    output logic       busy,
    output logic [7:0] rd_data,
    output logic       ack_fail,
    output logic       scl_low,
    output logic       sda_low,
    input  logic       sda_in
);

    localparam int AW = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1;
    localparam int DW = $clog2(RESET_WAIT + 1);
    localparam logic [AW:0]   ROM_END  = (AW+1)'(ROM_DEPTH);
    localparam logic [DW-1:0] DLY_LAST = DW'(RESET_WAIT - 1);

    typedef struct packed {
        stage_e      stage;
        op_e         op;
        logic        rxph;
        logic [1:0]  byte_idx;
        logic [3:0]  bit_idx;
        logic [7:0]  shreg;
        logic [7:0]  regad;
        logic [7:0]  wdat;
        logic [7:0]  rdat;
        logic        ackf;
        logic [AW:0] rom_idx;
        logic [DW-1:0] dly;
    } ctl_t;

    ctl_t s_q, s_d;

    logic       gen_go, gen_bit, gen_done, gen_smp;
    sym_e       gen_kind;
    logic [7:0] rom_reg, rom_val;
    logic       rx_byte, gap_after;
    logic [1:0] nbytes, nb;
    logic [7:0] nxt_byte;

    function automatic logic [7:0] sel_byte(input logic [1:0] idx, input logic rxph,
                                            input logic [7:0] r, input logic [7:0] d);
        case (idx)
            2'd0:    sel_byte = rxph ? DEV_RD_ADDR : DEV_WR_ADDR;
            2'd1:    sel_byte = r;
            default: sel_byte = d;
        endcase
    endfunction

    cam_init_rom #(
        .DEPTH (ROM_DEPTH),
        .AW    (AW),
        .LIST  (ROM_LIST)
    ) u_rom (
        .idx   (s_q.rom_idx[AW-1:0]),
        .reg_o (rom_reg),
        .val_o (rom_val)
    );

    cam_sym_gen #(
        .QTR     (QTR),
        .GAP_CYC (GAP_CYC)
    ) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (gen_go),
        .kind_i  (gen_kind),
        .bit_i   (gen_bit),
        .sda_in  (sda_in),
        .done    (gen_done),
        .scl_low (scl_low),
        .sda_low (sda_low),
        .smp     (gen_smp)
    );

    always_comb begin
        s_d      = s_q;
        gen_go   = 1'b0;
        gen_kind = SYM_START;
        gen_bit  = 1'b1;
        rx_byte   = s_q.rxph && (s_q.byte_idx == 2'd1);
        gap_after = (s_q.byte_idx == 2'd0) || ((s_q.byte_idx == 2'd1) && !s_q.rxph);
        nbytes    = (s_q.op == OP_READ) ? 2'd2 : 2'd3;
        nb        = s_q.byte_idx + 2'd1;
        nxt_byte  = sel_byte(nb, s_q.rxph, s_q.regad, s_q.wdat);

        case (s_q.stage)
            ST_IDLE: begin
                if (cmd_start) begin
                    s_d.op      = op_e'(cmd_op);
                    s_d.ackf    = 1'b0;
                    s_d.rxph    = 1'b0;
                    s_d.rom_idx = '0;
                    case (op_e'(cmd_op))
                        OP_INIT: s_d.stage = ST_FETCH;
                        OP_RESET: begin
                            s_d.regad = SOFT_RST_REG;
                            s_d.wdat  = SOFT_RST_VAL;
                            gen_go    = 1'b1;
                            s_d.stage = ST_START;
                        end
                        default: begin
                            s_d.regad = cmd_reg;
                            s_d.wdat  = cmd_wdata;
                            gen_go    = 1'b1;
                            s_d.stage = ST_START;
                        end
                    endcase
                end
            end
            ST_FETCH: begin
                if (s_q.rom_idx == ROM_END || (rom_reg == LIST_END && rom_val == LIST_END)) begin
                    s_d.stage = ST_IDLE;
                end else begin
                    s_d.regad = rom_reg;
                    s_d.wdat  = rom_val;
                    s_d.rxph  = 1'b0;
                    gen_go    = 1'b1;
                    s_d.stage = ST_START;
                end
            end
            ST_START: begin
                if (gen_done) begin
                    s_d.byte_idx = 2'd0;
                    s_d.bit_idx  = 4'd0;
                    s_d.shreg    = sel_byte(2'd0, s_q.rxph, s_q.regad, s_q.wdat);
                    gen_go       = 1'b1;
                    gen_kind     = SYM_BIT;
                    gen_bit      = s_d.shreg[7];
                    s_d.stage    = ST_BIT;
                end
            end
            ST_BIT: begin
                if (gen_done) begin
                    if (s_q.bit_idx != 4'd8) begin
                        s_d.shreg   = {s_q.shreg[6:0], rx_byte ? gen_smp : 1'b0};
                        s_d.bit_idx = s_q.bit_idx + 4'd1;
                        gen_go      = 1'b1;
                        gen_kind    = SYM_BIT;
                        gen_bit     = (s_q.bit_idx == 4'd7 || rx_byte) ? 1'b1 : s_q.shreg[6];
                    end else begin
                        if (rx_byte) begin
                            s_d.rdat = s_q.shreg;
                        end else begin
                            s_d.ackf = s_q.ackf | gen_smp;
                        end
                        gen_go = 1'b1;
                        if (gap_after) begin
                            gen_kind  = SYM_GAP;
                            s_d.stage = ST_GAP;
                        end else begin
                            gen_kind  = SYM_STOP;
                            s_d.stage = ST_STOP;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (gen_done) begin
                    gen_go = 1'b1;
                    if (nb < nbytes) begin
                        s_d.byte_idx = nb;
                        s_d.bit_idx  = 4'd0;
                        s_d.shreg    = nxt_byte;
                        gen_kind     = SYM_BIT;
                        gen_bit      = (s_q.rxph && nb == 2'd1) ? 1'b1 : nxt_byte[7];
                        s_d.stage    = ST_BIT;
                    end else begin
                        gen_kind  = SYM_STOP;
                        s_d.stage = ST_STOP;
                    end
                end
            end
            ST_STOP: begin
                if (gen_done) begin
                    if (s_q.op == OP_READ && !s_q.rxph) begin
                        s_d.rxph  = 1'b1;
                        gen_go    = 1'b1;
                        s_d.stage = ST_START;
                    end else if (s_q.op == OP_RESET) begin
                        s_d.dly   = '0;
                        s_d.stage = ST_DELAY;
                    end else if (s_q.op == OP_INIT) begin
                        s_d.rom_idx = s_q.rom_idx + (AW+1)'(1);
                        s_d.stage   = ST_FETCH;
                    end else begin
                        s_d.stage = ST_IDLE;
                    end
                end
            end
            ST_DELAY: begin
                if (s_q.dly == DLY_LAST) begin
                    s_d.stage = ST_IDLE;
                end else begin
                    s_d.dly = s_q.dly + DW'(1);
                end
            end
            default: s_d.stage = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.stage != ST_IDLE);
    assign rd_data  = s_q.rdat;
    assign ack_fail = s_q.ackf;

endmodule

// File: rtl/cam_ctl_checks.sv
module cam_ctl_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_start,
    input logic       busy,
    input logic       scl_low,
    input logic       sda_low,
    input logic [7:0] rd_data
);

    a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_start) |=> busy);

    a_r6_lines_free_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_low && !sda_low));

    a_r6_sda_quiet_under_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_low && $past(!scl_low) && (sda_low != $past(sda_low))) |-> busy);

    a_r8_rdata_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(rd_data));

    a_r11_release_before_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(!scl_low && !sda_low));

endmodule

bind cam_ctl_master cam_ctl_checks u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .busy      (busy),
    .scl_low   (scl_low),
    .sda_low   (sda_low),
    .rd_data   (rd_data)
);

// File: tb/tb_cam_ctl_master.sv
module tb_cam_ctl_master;

    localparam int QTR  = 2;
    localparam int GAP  = 5;
    localparam int WAIT = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_start = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [7:0] cmd_reg = 8'h00;
    logic [7:0] cmd_wdata = 8'h00;
    logic       busy, ack_fail, scl_low, sda_low, sda_in;
    logic [7:0] rd_data;
    logic       slv_low = 1'b0;

    always #5 clk = ~clk;

    assign sda_in = ~(sda_low | slv_low);

    cam_ctl_master #(
        .QTR        (QTR),
        .GAP_CYC    (GAP),
        .RESET_WAIT (WAIT)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .cmd_op    (cmd_op),
        .cmd_reg   (cmd_reg),
        .cmd_wdata (cmd_wdata),
        .busy      (busy),
        .rd_data   (rd_data),
        .ack_fail  (ack_fail),
        .scl_low   (scl_low),
        .sda_low   (sda_low),
        .sda_in    (sda_in)
    );

    typedef struct packed {
        logic scl;
        logic sda;
        logic slv;
    } ent_t;

    ent_t q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    logic exp_ackf;
    logic [7:0] last_rd = 8'h00;

    task automatic seg(input logic scl, input logic sda, input logic slv, input int n);
        for (int i = 0; i < n; i++) q.push_back(ent_t'{scl, sda, slv});
    endtask

    task automatic m_start();
        seg(1, 1, 0, QTR); seg(1, 0, 0, QTR); seg(0, 0, 0, 2*QTR);
    endtask

    task automatic m_stop();
        seg(0, 0, 0, QTR); seg(1, 0, 0, QTR); seg(1, 1, 0, 2*QTR);
    endtask

    task automatic m_bit(input logic sdam, input logic slv);
        seg(0, sdam, slv, QTR); seg(1, sdam, slv, 2*QTR); seg(0, sdam, slv, QTR);
    endtask

    task automatic m_tx(input logic [7:0] v, input logic ack);
        for (int i = 7; i >= 0; i--) m_bit(v[i], 1'b0);
        m_bit(1'b1, ack);
        if (!ack) exp_ackf = 1'b1;
    endtask

    task automatic m_rx(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) m_bit(1'b1, ~v[i]);
        m_bit(1'b1, 1'b0);
    endtask

    task automatic m_gap();
        seg(0, 1, 0, GAP);
    endtask

    task automatic m_write(input logic [7:0] r, input logic [7:0] d, input logic [2:0] acks);
        m_start();
        m_tx(8'h42, acks[0]); m_gap();
        m_tx(r, acks[1]);     m_gap();
        m_tx(d, acks[2]);
        m_stop();
    endtask

    task automatic m_read(input logic [7:0] r, input logic [7:0] v);
        m_start();
        m_tx(8'h42, 1'b1); m_gap();
        m_tx(r, 1'b1);     m_gap();
        m_stop();
        m_start();
        m_tx(8'h43, 1'b1); m_gap();
        m_rx(v);
        m_stop();
    endtask

    task automatic check(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Issues a command, then walks the expected per-cycle queue.
    task automatic run(input string tag, input logic [1:0] op, input logic [7:0] r,
                       input logic [7:0] d, input int poke);
        int   idx;
        int   mism;
        int   bad_at;
        logic [2:0] bad_got, bad_exp;
        ent_t e;
        @(negedge clk);
        cmd_op = op; cmd_reg = r; cmd_wdata = d; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        idx = 0; mism = 0; bad_at = 0; bad_got = '0; bad_exp = '0;
        while (q.size() > 0) begin
            e = q.pop_front();
            if (idx == poke) begin
                cmd_start = 1'b1; cmd_op = 2'd3; cmd_reg = 8'h55; cmd_wdata = 8'hAA;
            end else begin
                cmd_start = 1'b0;
            end
            if ({~scl_low, ~sda_low, busy} != {e.scl, e.sda, 1'b1}) begin
                if (mism == 0) begin
                    bad_at = idx; bad_got = {~scl_low, ~sda_low, busy}; bad_exp = {e.scl, e.sda, 1'b1};
                end
                mism++;
            end
            slv_low = e.slv;
            idx++;
            @(negedge clk);
        end
        slv_low = 1'b0;
        cmd_start = 1'b0;
        n_tests++;
        if (mism != 0) begin
            n_fail++;
            $display("FAIL %s bus trace at cycle %0d: got scl/sda/busy %b expected %b",
                     tag, bad_at, bad_got, bad_exp);
        end
        check({tag, " R11 busy low after command"}, int'(busy), 0);
        check({tag, " R8 rd_data"}, int'(rd_data), int'(last_rd));
        check({tag, " R7 ack_fail"}, int'(ack_fail), int'(exp_ackf));
        check({tag, " R6 lines released"}, int'({scl_low, sda_low}), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got run still active expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 scl_low", int'(scl_low), 0);
        check("R1 sda_low", int'(sda_low), 0);
        check("R1 rd_data", int'(rd_data), 0);
        check("R1 ack_fail", int'(ack_fail), 0);

        // R3/R5/R6 plain write, R2 start request during busy ignored
        q.delete(); exp_ackf = 1'b0;
        m_write(8'h3A, 8'h5C, 3'b111);
        run("R3/R5/R2 write", 2'd0, 8'h3A, 8'h5C, 40);

        // R7 slave refuses register byte, transfer runs on unchanged
        q.delete(); exp_ackf = 1'b0;
        m_write(8'hC3, 8'h01, 3'b101);
        run("R7 nack write", 2'd0, 8'hC3, 8'h01, -1);

        // R7 flag cleared by next command
        q.delete(); exp_ackf = 1'b0;
        m_write(8'h00, 8'hFF, 3'b111);
        run("R7 flag clear write", 2'd0, 8'h00, 8'hFF, -1);

        // R4/R8 two-phase read
        q.delete(); exp_ackf = 1'b0;
        m_read(8'h0A, 8'h76); last_rd = 8'h76;
        run("R4/R8 read", 2'd1, 8'h0A, 8'h00, 100);

        q.delete(); exp_ackf = 1'b0;
        m_read(8'h81, 8'hA5); last_rd = 8'hA5;
        run("R4/R8 read alt", 2'd1, 8'h81, 8'h33, -1);

        // R9 sensor reset then wait
        q.delete(); exp_ackf = 1'b0;
        m_write(8'h12, 8'h80, 3'b111);
        seg(1, 1, 0, WAIT);
        run("R9 sensor reset", 2'd2, 8'h77, 8'h66, 300);

        // R10 list with half-marker entry sent and full marker not sent
        q.delete(); exp_ackf = 1'b0;
        seg(1, 1, 0, 1);
        m_write(8'h11, 8'h80, 3'b111); seg(1, 1, 0, 1);
        m_write(8'h3B, 8'h1A, 3'b111); seg(1, 1, 0, 1);
        m_write(8'hFF, 8'h00, 3'b111); seg(1, 1, 0, 1);
        m_write(8'h0C, 8'h04, 3'b111); seg(1, 1, 0, 1);
        run("R10 init list", 2'd3, 8'h00, 8'h00, 500);

        // R8 read of all-zero byte after list, R11 back to back
        q.delete(); exp_ackf = 1'b0;
        m_read(8'h1C, 8'h00); last_rd = 8'h00;
        run("R8/R11 read zero", 2'd1, 8'h1C, 8'h00, -1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule